// File: doc/BRIEF.md
# Randomized Region Translation Table

This block sits in a memory controller in front of a wear-limited memory. It turns a block address from the system side into a block address on the device side. The address splits into a region index and an in-region offset. A per-region table entry supplies the target region on the device and a displacement. The device address is the target region joined to the offset XORed with that displacement. Each lookup reads the table once, so the result comes out one clock after the request.

The mapping keeps changing so that an attacker cannot predict it. On a write, a random word from outside the block is compared with a programmable threshold. When the random value is below the threshold, the block starts a remap. It chooses a partner region from other bits of the same random word. It then asks an external copy engine to exchange the contents of the two device regions. Once the engine acknowledges, the two table entries trade their target regions and both take new random displacements.

There is no write counter. The chance of a remap on each write is threshold / 2^TRIG_W.

Top module: `rrt_xlat`

## Requirements
- R1: After reset, entry i maps to device region i with displacement 0, so every address translates to itself.
- R2: For a request accepted in cycle t, `xlat_valid_o` is high in cycle t+1. In that cycle `xlat_addr_o` = {entry region, offset XOR entry displacement}, where the region index is the address bits above bit OFF_W and the offset is the low OFF_W bits.
- R3: A remap starts only on a valid write request whose trigger field rnd_i[TRIG_W-1:0] is below `thresh_i`. Read requests never start one.
- R4: With `thresh_i` = 0, no write starts a remap.
- R5: The partner index is rnd_i[TRIG_W +: RIDX_W]. When it equals the written region, the next index modulo the region count is used, so the two regions always differ.
- R6: `swap_valid_o` rises in the cycle after a trigger and stays high up to and including the cycle in which `swap_ack_i` is sampled. `swap_a_o` and `swap_b_o` carry the old device regions of the written entry and of the partner entry.
- R7: While a remap is pending, including its acknowledge cycle, further triggers are ignored and the command outputs hold.
- R8: Lookups use the old entries until the acknowledge edge. From the next cycle on, the written entry holds the partner's old region with displacement rnd_i[TRIG_W+RIDX_W +: OFF_W], and the partner holds the written entry's old region with displacement rnd_i[TRIG_W+RIDX_W+OFF_W +: OFF_W]. Both displacements are taken from the random word of the triggering cycle.
- R9: `swap_ack_i` with no remap pending has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_wr_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | System block address |
| thresh_i | input | TRIG_W | Remap threshold |
| rnd_i | input | TRIG_W+RIDX_W+2*OFF_W | Random word (trigger, partner, two displacements) |
| swap_ack_i | input | 1 | Copy engine finished the exchange |
| xlat_valid_o | output | 1 | Translated address valid |
| xlat_addr_o | output | ADDR_W | Device block address |
| swap_valid_o | output | 1 | Exchange command pending |
| swap_a_o | output | RIDX_W | Device region of the written entry |
| swap_b_o | output | RIDX_W | Device region of the partner entry |

## Verification
The bench builds the block with ADDR_W=8, OFF_W=3 and TRIG_W=4, which gives 32 regions of 8 blocks and a 4-bit threshold. With only 32 regions, random partner indices often collide with the written region, so the forced-different path is exercised many times. Over a few thousand random cycles, repeated remaps chain across most entries. The 4-bit threshold makes both extremes easy to reach: zero never triggers and 15 triggers on almost every write. An 8-entry offset space lets every displacement value show up at the outputs.

// File: rtl/rrt_pkg.sv
// Shared types for the randomized region translation table.
// Assumes nothing beyond standard SystemVerilog packages.
package rrt_pkg;
    // State of the remap handshake with the copy engine.
    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_WAIT = 1'b1
    } swap_state_e;
endpackage

// File: rtl/rrt_trigger.sv
// Remap trigger: decides from a random word whether a write starts a
// remap, and picks a partner region distinct from the written one.
// Assumes at least two regions (RIDX_W >= 1).
module rrt_trigger #(
    parameter int TRIG_W = 4,
    parameter int RIDX_W = 6
) (
    input  logic              req_valid_i,
    input  logic              req_wr_i,
    input  logic              busy_i,
    input  logic [TRIG_W-1:0] thresh_i,
    input  logic [TRIG_W-1:0] rnd_trig_i,
    input  logic [RIDX_W-1:0] rnd_part_i,
    input  logic [RIDX_W-1:0] own_idx_i,
    output logic              fire_o,
    output logic [RIDX_W-1:0] partner_o
);
    // Fire on a write when the random draw falls below the threshold.
    always_comb begin
        fire_o = req_valid_i && req_wr_i && !busy_i && (rnd_trig_i < thresh_i);
    end

    // Partner index, bumped to the next region when it collides.
    always_comb begin
        partner_o = (rnd_part_i == own_idx_i) ? own_idx_i + 1'b1 : rnd_part_i;
    end
endmodule

// File: rtl/rrt_table.sv
// Region table: one entry per region, holding device region and
// displacement. Two combinational read ports; on commit, two entries are
// rewritten at once. Assumes idx_a_i != idx_b_i whenever commit_i is high.
module rrt_table #(
    parameter int RIDX_W = 6,
    parameter int OFF_W  = 4,
    localparam int NREG  = 1 << RIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd0_idx_i,
    output logic [RIDX_W-1:0] rd0_reg_o,
    output logic [OFF_W-1:0]  rd0_disp_o,
    input  logic [RIDX_W-1:0] rd1_idx_i,
    output logic [RIDX_W-1:0] rd1_reg_o,
    input  logic              commit_i,
    input  logic [RIDX_W-1:0] idx_a_i,
    input  logic [RIDX_W-1:0] reg_a_i,
    input  logic [OFF_W-1:0]  disp_a_i,
    input  logic [RIDX_W-1:0] idx_b_i,
    input  logic [RIDX_W-1:0] reg_b_i,
    input  logic [OFF_W-1:0]  disp_b_i
);
    logic [NREG-1:0][RIDX_W-1:0] reg_q;
    logic [NREG-1:0][OFF_W-1:0]  disp_q;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        // Entry storage: identity at reset, rewritten by a committed swap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[g]  <= RIDX_W'(g);
                disp_q[g] <= '0;
            end else if (commit_i && (idx_a_i == RIDX_W'(g))) begin
                reg_q[g]  <= reg_a_i;
                disp_q[g] <= disp_a_i;
            end else if (commit_i && (idx_b_i == RIDX_W'(g))) begin
                reg_q[g]  <= reg_b_i;
                disp_q[g] <= disp_b_i;
            end
        end
    end

    // Read ports.
    always_comb begin
        rd0_reg_o  = reg_q[rd0_idx_i];
        rd0_disp_o = disp_q[rd0_idx_i];
        rd1_reg_o  = reg_q[rd1_idx_i];
    end

    // R8
    tbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(reg_q) && $stable(disp_q)));
endmodule

// File: rtl/rrt_swap_ctl.sv
// Swap controller: captures a triggered remap, issues the exchange
// command to the copy engine, and commits the new entries on acknowledge.
// Assumes the table does not change while a remap is pending.
module rrt_swap_ctl
    import rrt_pkg::*;
#(
    parameter int RIDX_W = 6,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              ack_i,
    input  logic [RIDX_W-1:0] idx_a_i,
    input  logic [RIDX_W-1:0] idx_b_i,
    input  logic [RIDX_W-1:0] reg_a_i,
    input  logic [RIDX_W-1:0] reg_b_i,
    input  logic [OFF_W-1:0]  disp_a_i,
    input  logic [OFF_W-1:0]  disp_b_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic [RIDX_W-1:0] idx_a_o,
    output logic [RIDX_W-1:0] idx_b_o,
    output logic [RIDX_W-1:0] reg_a_o,
    output logic [RIDX_W-1:0] reg_b_o,
    output logic [OFF_W-1:0]  disp_a_o,
    output logic [OFF_W-1:0]  disp_b_o
);
    swap_state_e st_q;

    // Handshake state: idle until a trigger, wait until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SW_IDLE;
        end else if (st_q == SW_IDLE && fire_i) begin
            st_q <= SW_WAIT;
        end else if (st_q == SW_WAIT && ack_i) begin
            st_q <= SW_IDLE;
        end
    end

    // Capture the pending remap's indices, old regions and displacements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_a_o  <= '0;
            idx_b_o  <= '0;
            reg_a_o  <= '0;
            reg_b_o  <= '0;
            disp_a_o <= '0;
            disp_b_o <= '0;
        end else if (st_q == SW_IDLE && fire_i) begin
            idx_a_o  <= idx_a_i;
            idx_b_o  <= idx_b_i;
            reg_a_o  <= reg_a_i;
            reg_b_o  <= reg_b_i;
            disp_a_o <= disp_a_i;
            disp_b_o <= disp_b_i;
        end
    end

    // Status and commit strobe.
    always_comb begin
        busy_o   = (st_q == SW_WAIT);
        commit_o = (st_q == SW_WAIT) && ack_i;
    end

    // R7
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_i) |=> (busy_o && $stable(idx_a_o) && $stable(idx_b_o)
                                && $stable(reg_a_o) && $stable(reg_b_o)));
    // R5
    distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idx_a_o != idx_b_o));
endmodule

// File: rtl/rrt_xlat.sv
// Top of the randomized region translation table. Splits the address into
// region index and offset, translates through the table with one cycle of
// latency, and drives random remaps through the swap controller.
// Assumes rnd_i is fresh every cycle and the copy engine acks once per command.
module rrt_xlat #(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 4,
    parameter int TRIG_W = 4,
    localparam int RIDX_W = ADDR_W - OFF_W,
    localparam int RND_W  = TRIG_W + RIDX_W + 2 * OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [TRIG_W-1:0] thresh_i,
    input  logic [RND_W-1:0]  rnd_i,
    input  logic              swap_ack_i,
    output logic              xlat_valid_o,
    output logic [ADDR_W-1:0] xlat_addr_o,
    output logic              swap_valid_o,
    output logic [RIDX_W-1:0] swap_a_o,
    output logic [RIDX_W-1:0] swap_b_o
);
    logic [RIDX_W-1:0] req_idx, partner, rd0_reg, rd1_reg;
    logic [OFF_W-1:0]  req_off, rd0_disp;
    logic              fire, busy, commit;
    logic [RIDX_W-1:0] p_idx_a, p_idx_b, p_reg_a, p_reg_b;
    logic [OFF_W-1:0]  p_disp_a, p_disp_b;

    // Address split.
    always_comb begin
        req_idx = req_addr_i[ADDR_W-1:OFF_W];
        req_off = req_addr_i[OFF_W-1:0];
    end

    rrt_trigger #(.TRIG_W(TRIG_W), .RIDX_W(RIDX_W)) u_trig (
        .req_valid_i (req_valid_i),
        .req_wr_i    (req_wr_i),
        .busy_i      (busy),
        .thresh_i    (thresh_i),
        .rnd_trig_i  (rnd_i[TRIG_W-1:0]),
        .rnd_part_i  (rnd_i[TRIG_W +: RIDX_W]),
        .own_idx_i   (req_idx),
        .fire_o      (fire),
        .partner_o   (partner)
    );

    rrt_table #(.RIDX_W(RIDX_W), .OFF_W(OFF_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd0_idx_i  (req_idx),
        .rd0_reg_o  (rd0_reg),
        .rd0_disp_o (rd0_disp),
        .rd1_idx_i  (partner),
        .rd1_reg_o  (rd1_reg),
        .commit_i   (commit),
        .idx_a_i    (p_idx_a),
        .reg_a_i    (p_reg_b),
        .disp_a_i   (p_disp_a),
        .idx_b_i    (p_idx_b),
        .reg_b_i    (p_reg_a),
        .disp_b_i   (p_disp_b)
    );

    rrt_swap_ctl #(.RIDX_W(RIDX_W), .OFF_W(OFF_W)) u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .ack_i    (swap_ack_i),
        .idx_a_i  (req_idx),
        .idx_b_i  (partner),
        .reg_a_i  (rd0_reg),
        .reg_b_i  (rd1_reg),
        .disp_a_i (rnd_i[TRIG_W+RIDX_W +: OFF_W]),
        .disp_b_i (rnd_i[TRIG_W+RIDX_W+OFF_W +: OFF_W]),
        .busy_o   (busy),
        .commit_o (commit),
        .idx_a_o  (p_idx_a),
        .idx_b_o  (p_idx_b),
        .reg_a_o  (p_reg_a),
        .reg_b_o  (p_reg_b),
        .disp_a_o (p_disp_a),
        .disp_b_o (p_disp_b)
    );

    // Registered translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlat_valid_o <= 1'b0;
            xlat_addr_o  <= '0;
        end else begin
            xlat_valid_o <= req_valid_i;
            if (req_valid_i) begin
                xlat_addr_o <= {rd0_reg, req_off ^ rd0_disp};
            end
        end
    end

    // Command outputs to the copy engine.
    always_comb begin
        swap_valid_o = busy;
        swap_a_o     = p_reg_a;
        swap_b_o     = p_reg_b;
    end

    // R2
    xlat_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> xlat_valid_o);
    // R3
    wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_valid_o && !(req_valid_i && req_wr_i)) |=> !swap_valid_o);
    // R4
    zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_valid_o && thresh_i == '0) |=> !swap_valid_o);
    // R5
    distinct_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_valid_o |-> (swap_a_o != swap_b_o));
endmodule

// File: tb/rrt_xlat_bench.sv
module rrt_xlat_bench;
    localparam int ADDR_W = 8;
    localparam int OFF_W  = 3;
    localparam int TRIG_W = 4;
    localparam int RIDX_W = ADDR_W - OFF_W;
    localparam int RND_W  = TRIG_W + RIDX_W + 2 * OFF_W;
    localparam int NREG   = 1 << RIDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0, ack = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [TRIG_W-1:0] thresh = '0;
    logic [RND_W-1:0]  rnd = '0;
    logic xv, sv;
    logic [ADDR_W-1:0] xa;
    logic [RIDX_W-1:0] sa, sb;

    always #10 clk = ~clk;

    rrt_xlat #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TRIG_W(TRIG_W)) u_rrt_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_wr_i(req_wr),
        .req_addr_i(addr), .thresh_i(thresh), .rnd_i(rnd), .swap_ack_i(ack),
        .xlat_valid_o(xv), .xlat_addr_o(xa), .swap_valid_o(sv),
        .swap_a_o(sa), .swap_b_o(sb)
    );

    int checks = 0, errors = 0;
    int m_reg[NREG], m_disp[NREG];
    int pend, pa, pb, pra, prb, pda, pdb;
    int e_xv, e_xa, e_sv, e_sa, e_sb;
    int seed = 32'h1234_5677;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin m_reg[i] = i; m_disp[i] = 0; end
        pend = 0; e_xv = 0; e_xa = 0; e_sv = 0; e_sa = 0; e_sb = 0;
    endtask

    // One clock: model next state from current inputs, then compare.
    task automatic step();
        int r, off, trg, part;
        r    = int'(addr) >> OFF_W;
        off  = int'(addr) & ((1 << OFF_W) - 1);
        trg  = int'(rnd) & ((1 << TRIG_W) - 1);
        part = (int'(rnd) >> TRIG_W) & (NREG - 1);
        e_xv = req_valid;
        if (req_valid) e_xa = (m_reg[r] << OFF_W) | (off ^ m_disp[r]);
        if (pend != 0) begin
            if (ack) begin
                m_reg[pa] = prb; m_disp[pa] = pda;
                m_reg[pb] = pra; m_disp[pb] = pdb;
                pend = 0;
            end
        end else if (req_valid && req_wr && trg < int'(thresh)) begin
            pend = 1; pa = r;
            pb = (part == r) ? ((r + 1) % NREG) : part;
            pra = m_reg[pa]; prb = m_reg[pb];
            pda = (int'(rnd) >> (TRIG_W + RIDX_W)) & ((1 << OFF_W) - 1);
            pdb = (int'(rnd) >> (TRIG_W + RIDX_W + OFF_W)) & ((1 << OFF_W) - 1);
            e_sa = pra; e_sb = prb;
        end
        e_sv = pend;
        @(posedge clk);
        @(negedge clk);
        chk("R2 xlat_valid", int'(xv), e_xv);
        chk("R2/R8 xlat_addr", int'(xa), e_xa);
        chk("R3/R6 swap_valid", int'(sv), e_sv);
        chk("R6 swap_a", int'(sa), e_sa);
        chk("R5/R6 swap_b", int'(sb), e_sb);
    endtask

    task automatic drive(input bit v, input bit w, input int a, input int t,
                         input int rn, input bit k);
        req_valid = v; req_wr = w; addr = ADDR_W'(a); thresh = TRIG_W'(t);
        rnd = RND_W'(rn); ack = k;
        step();
    endtask

    function automatic int mk_rnd(input int trg, input int part, input int da, input int db);
        return trg | (part << TRIG_W) | (da << (TRIG_W + RIDX_W))
                   | (db << (TRIG_W + RIDX_W + OFF_W));
    endfunction

    function automatic int nextr();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 32'h7fff_ffff;
    endfunction

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        chk("R1 reset swap_valid", int'(sv), 0);
        chk("R1 reset xlat_valid", int'(xv), 0);
        rst_n = 1'b1;
        // R1: identity after reset
        for (int i = 0; i < 6; i++) begin
            drive(1, 0, i * 41 % 256, 0, 0, 0);
            chk("R1 identity", int'(xa), i * 41 % 256);
        end
        // R4: zero threshold never triggers
        drive(1, 1, 12, 0, mk_rnd(0, 3, 1, 1), 0);
        chk("R4 no trigger", int'(sv), 0);
        // R3: reads never trigger
        drive(1, 0, 12, 15, mk_rnd(0, 3, 1, 1), 0);
        chk("R3 read no trigger", int'(sv), 0);
        // R3/R5: write triggers, partner collides with own region 5 -> 6
        drive(1, 1, 5 * 8 + 1, 15, mk_rnd(0, 5, 3, 6), 0);
        chk("R3 trigger", int'(sv), 1);
        chk("R5 partner bumped", int'(sb), 6);
        chk("R6 swap_a", int'(sa), 5);
        // R7: new trigger while pending ignored
        drive(1, 1, 9 * 8, 15, mk_rnd(0, 20, 1, 1), 0);
        chk("R7 ignored", int'(sa), 5);
        // R8: old entry before ack, and in the ack cycle
        drive(1, 0, 5 * 8 + 2, 15, 0, 0);
        chk("R8 old before ack", int'(xa), 42);
        drive(1, 1, 5 * 8 + 2, 15, mk_rnd(0, 9, 0, 0), 1);
        chk("R8 old in ack cycle", int'(xa), 42);
        chk("R7 no trigger in ack cycle", int'(sv), 0);
        drive(1, 0, 5 * 8 + 2, 15, 0, 0);
        chk("R8 new entry A", int'(xa), 49);
        drive(1, 0, 6 * 8, 15, 0, 0);
        chk("R8 new entry B", int'(xa), 46);
        // R9: ack without pending has no effect
        drive(0, 0, 0, 0, 0, 1);
        drive(1, 0, 5 * 8 + 2, 0, 0, 0);
        chk("R9 ack idle", int'(xa), 49);
        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int a, b;
            a = nextr(); b = nextr();
            drive(a[0] | a[1], a[2], (a >> 3) & 255, (n < 2000) ? 6 : 15,
                  b & ((1 << RND_W) - 1), (a[9:8] == 2'b00));
        end
        // reset mid-run returns to identity (R1)
        rst_n = 1'b0; model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 5 * 8 + 2, 0, 0, 0);
        chk("R1 identity after reset", int'(xa), 42);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule